// File: doc/BRIEF.md
# Masked Packet Reducer

This block folds a stream of 8-lane flits of signed 32-bit integers into one result per reduction group. Some lanes or whole flits are padding, and the block leaves them out. The caller picks the operator, the reduction mode and the group length on a configuration port. These settings are sampled when the first flit of a group is accepted. Flits arrive on a valid/ready input that also carries two tags: a prefix valid count and a whole-flit keep bit. The block does not zero-fill padding beforehand. Instead, every excluded element is replaced by the identity of the operator, so it cannot change the result.

Time mode (`cfg_pkt_mode` = 0) keeps eight independent lane accumulators. Each lane collapses the time steps of a group into a single value, and the keep bit gates each whole flit. Packet mode (`cfg_pkt_mode` = 1) folds the valid prefix of each flit, and every flit of the group, into one scalar. That scalar is returned on lane 0.

A three-state controller sequences the work:
- `ST_IDLE`: waits for the first flit of a group. Accepting it latches the configuration and starts the fold from the identity. The controller moves to `ST_EMIT` when the group length is one, and to `ST_ACCUM` otherwise.
- `ST_ACCUM`: folds each accepted flit into the accumulators. It moves to `ST_EMIT` when the flit just accepted completes the group.
- `ST_EMIT`: presents the result for one cycle with the input stalled, then always returns to `ST_IDLE`.

Top module: `mrd_reducer`

## Requirements
- R1: After reset `res_valid` is 0 and `in_ready` is 1.
- R2: A group ends after the number of accepted flits given by the group length. `res_valid` is then 1 in the cycle after the last accepted flit, for exactly one cycle, and `in_ready` is 0 during that cycle.
- R3: In time mode, lane i of the result is the lane-i fold of every flit of the group whose `in_keep` is 1. A flit with `in_keep` = 0 contributes nothing, and `in_vc` is ignored.
- R4: In packet mode, only positions i < `in_vc` take part. A count above 8 acts as 8 and `in_keep` is ignored. Result lanes 1..7 hold the operator identity.
- R5: In packet mode, elements are folded one at a time into the running scalar, position 0 to 7 within a flit and flit after flit. Saturation therefore applies at every step.
- R6: `cfg_op` 0 is saturating add. A sum above 0x7FFFFFFF gives 0x7FFFFFFF, and a sum below 0x80000000 gives 0x80000000.
- R7: `cfg_op` 1 is wrapping two's-complement add, and `cfg_op` 3 behaves the same as 1.
- R8: `cfg_op` 2 is signed minimum.
- R9: A result with no included element equals the identity: 0x7FFFFFFF for minimum, and 0 for both adds.
- R10: Each group restarts from the identity. `cfg_op`, `cfg_pkt_mode` and `cfg_len` are sampled only with the group's first flit, so later changes do not affect the group.
- R11: A `cfg_len` of 0 acts as a group length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_op | input | 2 | Operator: 0 saturating add, 1 add, 2 min, 3 add |
| cfg_pkt_mode | input | 1 | 1 selects packet mode, 0 selects time mode |
| cfg_len | input | 8 | Flits per group (0 acts as 1) |
| in_valid | input | 1 | Flit offered |
| in_ready | output | 1 | Flit can be accepted |
| in_data | input | 256 | Eight 32-bit lanes, lane i at bits 32i+31:32i |
| in_vc | input | 4 | Prefix valid count for packet mode |
| in_keep | input | 1 | Whole-flit valid bit for time mode |
| res_valid | output | 1 | Result valid, one-cycle pulse |
| res_data | output | 256 | Result lanes, same layout as `in_data` |

## Verification
The assertions check the controller's contract on every cycle. They confirm that `res_valid` is a one-cycle pulse with the input stalled, and that the number of flits accepted before each pulse equals the latched group length (zero counting as one). In packet mode they also check that the unused lanes carry the operator's identity. The arithmetic can only be shown by the bench's scenarios, because each case needs a specific data pattern. These cases are saturation in both directions, the sequential fold order, masking by prefix count and keep bit, all-excluded groups, and configuration changes in the middle of a group.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
    typedef enum logic [1:0] {
        OP_SADD = 2'd0,
        OP_ADD  = 2'd1,
        OP_MIN  = 2'd2,
        OP_ADD2 = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_EMIT  = 2'd2
    } state_e;
endpackage

// File: rtl/mrd_combine.sv
module mrd_combine
    import mrd_pkg::*;
#(
    parameter int DW = 32
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] wide;

    always_comb begin
        wide = {a[DW-1], a} + {b[DW-1], b};
        unique case (op)
            OP_SADD: begin
                if (wide[DW] != wide[DW-1]) y = wide[DW] ? SMIN : SMAX;
                else                        y = wide[DW-1:0];
            end
            OP_MIN:  y = ($signed(a) < $signed(b)) ? a : b;
            default: y = wide[DW-1:0];
        endcase
    end
endmodule

// File: rtl/mrd_mask.sv
module mrd_mask
    import mrd_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 32,
    parameter int VC_W  = 4
) (
    input  op_e                 op,
    input  logic                pkt_mode,
    input  logic                keep,
    input  logic [VC_W-1:0]     vc,
    input  logic [LANES*DW-1:0] din,
    output logic [LANES*DW-1:0] dout
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

    logic [DW-1:0] ident;
    assign ident = (op == OP_MIN) ? SMAX : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic take;
        assign take = pkt_mode ? (VC_W'(i) < vc) : keep;
        assign dout[i*DW +: DW] = take ? din[i*DW +: DW] : ident;
    end
endmodule

// File: rtl/mrd_fold.sv
module mrd_fold
    import mrd_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 32
) (
    input  op_e                 op,
    input  logic                pkt_mode,
    input  logic [LANES*DW-1:0] acc,
    input  logic [LANES*DW-1:0] elem,
    output logic [LANES*DW-1:0] nxt
);
    logic [DW-1:0] chain [LANES+1];
    assign chain[0] = acc[DW-1:0];

    for (genvar i = 0; i < LANES; i++) begin : g_stage
        logic [DW-1:0] lhs;
        assign lhs = pkt_mode ? chain[i] : acc[i*DW +: DW];
        mrd_combine #(.DW(DW)) u_cmb (
            .op (op),
            .a  (lhs),
            .b  (elem[i*DW +: DW]),
            .y  (chain[i+1])
        );
        if (i == 0) begin : g_first
            assign nxt[DW-1:0] = pkt_mode ? chain[LANES] : chain[1];
        end else begin : g_rest
            assign nxt[i*DW +: DW] = pkt_mode ? acc[i*DW +: DW] : chain[i+1];
        end
    end
endmodule

// File: rtl/mrd_reducer.sv
module mrd_reducer
    import mrd_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 32,
    parameter int LEN_W = 8,
    parameter int VC_W  = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_op,
    input  logic                cfg_pkt_mode,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [LANES*DW-1:0] in_data,
    input  logic [VC_W-1:0]     in_vc,
    input  logic                in_keep,
    output logic                res_valid,
    output logic [LANES*DW-1:0] res_data
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

    state_e             state, state_nx;
    op_e                grp_op;
    logic               grp_pkt;
    logic [LEN_W-1:0]   grp_len;
    logic [LEN_W-1:0]   cnt;
    logic [LANES*DW-1:0] acc;

    op_e                sel_op;
    logic               sel_pkt;
    logic [LEN_W:0]     eff_len;
    logic [LANES*DW-1:0] base, masked, folded;
    logic               take;
    logic               last;

    // Configuration in use: live inputs for the first flit, latched ones after.
    always_comb begin
        if (state == ST_IDLE) begin
            sel_op  = op_e'(cfg_op);
            sel_pkt = cfg_pkt_mode;
            eff_len = (cfg_len == '0) ? (LEN_W+1)'(1) : {1'b0, cfg_len};
            base    = {LANES{(op_e'(cfg_op) == OP_MIN) ? SMAX : {DW{1'b0}}}};
        end else begin
            sel_op  = grp_op;
            sel_pkt = grp_pkt;
            eff_len = (grp_len == '0) ? (LEN_W+1)'(1) : {1'b0, grp_len};
            base    = acc;
        end
    end

    mrd_mask #(.LANES(LANES), .DW(DW), .VC_W(VC_W)) u_mask (
        .op       (sel_op),
        .pkt_mode (sel_pkt),
        .keep     (in_keep),
        .vc       (in_vc),
        .din      (in_data),
        .dout     (masked)
    );

    mrd_fold #(.LANES(LANES), .DW(DW)) u_fold (
        .op       (sel_op),
        .pkt_mode (sel_pkt),
        .acc      (base),
        .elem     (masked),
        .nxt      (folded)
    );

    assign take = in_valid && in_ready;
    assign last = ((state == ST_IDLE) ? (LEN_W+1)'(1) : ({1'b0, cnt} + 1'b1)) >= eff_len;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (take) state_nx = last ? ST_EMIT : ST_ACCUM;
            ST_ACCUM: if (take && last) state_nx = ST_EMIT;
            ST_EMIT:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Group registers and accumulators
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_op  <= OP_SADD;
            grp_pkt <= 1'b0;
            grp_len <= '0;
            cnt     <= '0;
            acc     <= '0;
        end else if (take) begin
            acc <= folded;
            if (state == ST_IDLE) begin
                grp_op  <= op_e'(cfg_op);
                grp_pkt <= cfg_pkt_mode;
                grp_len <= cfg_len;
                cnt     <= LEN_W'(1);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state != ST_EMIT);
        res_valid = (state == ST_EMIT);
        res_data  = acc;
    end
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker
    import mrd_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 32,
    parameter int LEN_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                res_valid,
    input logic [LANES*DW-1:0] res_data,
    input op_e                 grp_op,
    input logic                grp_pkt,
    input logic [LEN_W-1:0]    grp_len
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

    logic [LEN_W:0] seen;
    logic [LEN_W:0] want;
    logic           tail_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    seen <= '0;
        else if (res_valid)            seen <= '0;
        else if (in_valid && in_ready) seen <= seen + 1'b1;
    end

    always_comb begin
        want    = (grp_len == '0) ? (LEN_W+1)'(1) : {1'b0, grp_len};
        tail_ok = 1'b1;
        for (int i = 1; i < LANES; i++)
            if (res_data[i*DW +: DW] != ((grp_op == OP_MIN) ? SMAX : {DW{1'b0}}))
                tail_ok = 1'b0;
    end

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);                                   // R2
    AST_STALL_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_ready);                                    // R2
    AST_GROUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (seen == want));                               // R11
    AST_PKT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && grp_pkt) |-> tail_ok);                         // R4
endmodule

bind mrd_reducer mrd_checker #(.LANES(LANES), .DW(DW), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .grp_op    (grp_op),
    .grp_pkt   (grp_pkt),
    .grp_len   (grp_len)
);

// File: tb/sim_mrd_reducer.sv
`timescale 1ns/1ps
module sim_mrd_reducer;
    localparam int LANES = 8;
    localparam int DW    = 32;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [1:0]   cfg_op = 0;
    logic         cfg_pkt_mode = 0;
    logic [7:0]   cfg_len = 1;
    logic         in_valid = 0;
    logic         in_ready;
    logic [255:0] in_data = '0;
    logic [3:0]   in_vc = 0;
    logic         in_keep = 0;
    logic         res_valid;
    logic [255:0] res_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int fd [16][8];
    int fvc [16];
    bit fk [16];
    int exp_l [8];

    always #2 clk = ~clk;

    mrd_reducer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_op(cfg_op), .cfg_pkt_mode(cfg_pkt_mode),
        .cfg_len(cfg_len), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_vc(in_vc), .in_keep(in_keep),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic int ident(int op);
        return (op == 2) ? 32'h7FFFFFFF : 0;
    endfunction

    function automatic int cmb(int op, int a, int b);
        longint s;
        s = longint'(a) + longint'(b);
        case (op)
            0: begin
                if (s > 64'sh7FFFFFFF) return 32'h7FFFFFFF;
                if (s < -64'sh80000000) return 32'h80000000;
                return int'(s);
            end
            2: return (a < b) ? a : b;
            default: return a + b;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic run_group(int op, bit pkt, int len, bit scramble, string tag);
        int n;
        n = (len == 0) ? 1 : len;
        for (int i = 0; i < 8; i++) exp_l[i] = ident(op);
        cfg_op = 2'(op); cfg_pkt_mode = pkt; cfg_len = 8'(len);
        for (int f = 0; f < n; f++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            if (f == 1 && scramble) begin
                cfg_op = 2'(op + 2); cfg_pkt_mode = ~pkt; cfg_len = 8'd1;
            end
            in_valid = 1;
            for (int i = 0; i < 8; i++) in_data[i*32 +: 32] = fd[f][i];
            in_vc = 4'(fvc[f]); in_keep = fk[f];
            if (pkt) begin
                for (int i = 0; i < 8; i++)
                    if (i < fvc[f]) exp_l[0] = cmb(op, exp_l[0], fd[f][i]);
            end else if (fk[f]) begin
                for (int i = 0; i < 8; i++) exp_l[i] = cmb(op, exp_l[i], fd[f][i]);
            end
        end
        @(negedge clk);
        in_valid = 0;
        chk(res_valid == 1 && in_ready == 0, {"R2 emit ", tag}, {res_valid, in_ready}, 2'b10);
        begin
            bit ok = 1;
            int bad = 0;
            for (int i = 7; i >= 0; i--)
                if (res_data[i*32 +: 32] != 32'(exp_l[i])) begin ok = 0; bad = i; end
            chk(ok, $sformatf("%s lane%0d", tag, bad), res_data[bad*32 +: 32], 32'(exp_l[bad]));
        end
        @(negedge clk);
        chk(res_valid == 0, {"R2 pulse ", tag}, res_valid, 0);
    endtask

    task automatic fill(int f, int v);
        for (int i = 0; i < 8; i++) fd[f][i] = v;
        fvc[f] = 8; fk[f] = 1;
    endtask

    function automatic int pick();
        case ($urandom % 4)
            0: return 32'h7FFFFFF0 + int'($urandom % 16);
            1: return 32'h80000000 + int'($urandom % 16);
            2: return int'($urandom % 64) - 32;
            default: return int'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(res_valid == 0 && in_ready == 1, "R1 reset", {res_valid, in_ready}, 2'b01);
        rst_n = 1;
        @(negedge clk);
        chk(res_valid == 0 && in_ready == 1, "R1 after reset", {res_valid, in_ready}, 2'b01);

        // R6 saturation both directions, time mode
        fill(0, 32'h7FFFFFF0); fd[0][1] = 32'h80000010;
        fill(1, 32'h100);      fd[1][1] = -32'h100;
        run_group(0, 0, 2, 0, "R6 sat");
        // R7 wrapping add, codes 1 and 3
        run_group(1, 0, 2, 0, "R7 add op1");
        run_group(3, 0, 2, 0, "R7 add op3");
        // R8 signed minimum
        fill(0, 5); fd[0][2] = -7; fill(1, -3); fd[1][4] = 32'h80000000;
        run_group(2, 0, 2, 0, "R8 min");
        // R3 keep=0 flit ignored, vc ignored in time mode
        fill(0, 10); fvc[0] = 0;
        fill(1, 32'h7FFFFFFF); fk[1] = 0;
        fill(2, 1); fvc[2] = 2;
        run_group(0, 0, 3, 0, "R3 gate");
        // R9 all excluded
        fill(0, -9); fk[0] = 0; fill(1, -9); fk[1] = 0;
        run_group(2, 0, 2, 0, "R9 min empty");
        fill(0, 44); fvc[0] = 0;
        run_group(1, 1, 1, 0, "R9 pkt vc0");
        // R4 prefix count, vc above 8, keep ignored
        for (int i = 0; i < 8; i++) fd[0][i] = i + 1;
        fvc[0] = 3; fk[0] = 0;
        for (int i = 0; i < 8; i++) fd[1][i] = 100 * (i + 1);
        fvc[1] = 12; fk[1] = 0;
        run_group(1, 1, 2, 0, "R4 prefix");
        run_group(2, 1, 2, 0, "R4 min pkt");
        // R5 sequential fold order with saturation
        fill(0, 0); fd[0][0] = 32'h7FFFFFFF; fd[0][1] = 1; fd[0][2] = -5; fvc[0] = 3;
        run_group(0, 1, 1, 0, "R5 order");
        // R11 length zero
        fill(0, 77);
        run_group(1, 0, 0, 0, "R11 len0");
        // R10 mid-group config change, then restart
        fill(0, 3); fill(1, 4); fill(2, 5);
        run_group(0, 0, 3, 1, "R10 cfg hold");
        run_group(0, 0, 3, 0, "R10 restart");

        // Random groups
        for (int g = 0; g < 60; g++) begin
            int op, len;
            bit pkt;
            op = int'($urandom % 4); pkt = 1'($urandom % 2); len = int'($urandom % 7);
            for (int f = 0; f < 16; f++) begin
                for (int i = 0; i < 8; i++) fd[f][i] = pick();
                fvc[f] = int'($urandom % 16); fk[f] = 1'($urandom % 2);
            end
            run_group(op, pkt, len, 1'($urandom % 2), $sformatf("R3 R4 rnd%0d", g));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule